// File: doc/BRIEF.md
# Event Interrupt Mask and Pending Register

This block collects single-cycle event pulses from up to eight sources into a byte-wide pending register and raises one level-sensitive interrupt while anything is pending. The host owns a single byte register: writing it sets which sources are allowed to latch events. Reading it returns the pending events of the allowed sources.

No acknowledge register exists. To clear a pending event, the host writes the mask again with that source's bit at zero. The pending bit drops, and the host may restore the full mask at once. A later event on the restored source latches again.

A fixed parameter mask names the sources that physically exist. Sources outside it can never be enabled and never show as pending. Bit n of every vector (event input, write data, read data) belongs to source n.

Top module: `evt_irq_ctl`

## Requirements
- R1: While reset is asserted and directly after it, `rd_data` reads 8'h00 and `irq_o` is 0; the mask is all zero, so events arriving straight after reset are discarded.
- R2: A write (`wr_en` high) stores `wr_data & VALID_MASK` as the mask at the clock edge. An `evt_i` bit n pulsing while mask bit n is already set makes `rd_data` bit n read 1 after that same clock edge.
- R3: An event on a source whose mask bit is 0 is discarded. Its `rd_data` bit stays 0, also after the source is later enabled.
- R4: A pending bit is sticky. Further events on the same source, and writes that keep its mask bit at 1, leave it at 1.
- R5: A write with bit n at 0 clears pending bit n at that edge. Writing the bit back to 1 afterwards does not bring the old event back.
- R6: Once a source is re-enabled after an acknowledge, a new event on it latches again.
- R7: When an event on source n and a write with bit n at 0 fall in the same cycle, the disable wins and pending bit n reads 0.
- R8: `rd_data` bits outside `VALID_MASK` (bits 6 and 7 by default, mask 8'h3F) always read 0. Writing 1 to them and pulsing their events has no effect.
- R9: `irq_o` is a register output. In every cycle it is 1 exactly when `rd_data` is nonzero.
- R10: A mask bit written to 1 takes effect from the next cycle. An event in the same cycle as the enabling write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the mask |
| wr_data | input | 8 | New mask value, bit n enables source n |
| evt_i | input | 8 | Event pulses, bit n from source n |
| rd_data | output | 8 | Pending events of enabled valid sources |
| irq_o | output | 1 | Level interrupt, high while any bit is pending |

## Verification
A host write of the mask and an event pulse can land in the same cycle, and the two orderings have opposite outcomes. A write that clears a bit must kill an event arriving with it (R7). A write that sets a bit must not catch an event arriving with it (R10). The bench drives both collisions on purpose, plus a write that keeps a pending source enabled while it fires again. A reference model applies the old mask to the event and the new mask to the result, and each following cycle's `rd_data` and `irq_o` are compared against that model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    // byte-wide host register: one bit per event source
    localparam int unsigned NSRC = 8;
    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t mask;
    } en_state_t;

    typedef struct packed {
        logic pend;
    } cell_state_t;

    typedef struct packed {
        logic irq;
    } irq_state_t;
endpackage

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg
    import irqc_pkg::*;
#(
    parameter src_vec_t VALID = 8'h3F
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  src_vec_t wr_data,
    output src_vec_t en_q,
    output src_vec_t en_d
);
    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mask = wr_data & VALID;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q = st_q.mask;
    assign en_d = st_d.mask;
endmodule

// File: rtl/irqc_status_cell.sv
module irqc_status_cell
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_cur,   // mask bit before this edge: gates the event
    input  logic en_nxt,   // mask bit after this edge: clears on disable
    input  logic evt,
    output logic pend_q,
    output logic pend_d
);
    cell_state_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (evt && en_cur) begin
            c_d.pend = 1'b1;
        end
        if (!en_nxt) begin
            c_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign pend_q = c_q.pend;
    assign pend_d = c_d.pend;
endmodule

// File: rtl/irqc_irq_out.sv
module irqc_irq_out
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t pend_nxt,
    output logic     irq_o
);
    irq_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.irq = |pend_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_o = s_q.irq;
endmodule

// File: rtl/evt_irq_ctl.sv
module evt_irq_ctl
    import irqc_pkg::*;
#(
    parameter src_vec_t VALID_MASK = 8'h3F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [7:0] evt_i,
    output logic [7:0] rd_data,
    output logic       irq_o
);
    src_vec_t en_q, en_d, pend_q, pend_d;

    irqc_enable_reg #(.VALID(VALID_MASK)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .en_q    (en_q),
        .en_d    (en_d)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (VALID_MASK[i]) begin : g_live
            irqc_status_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .en_cur (en_q[i]),
                .en_nxt (en_d[i]),
                .evt    (evt_i[i]),
                .pend_q (pend_q[i]),
                .pend_d (pend_d[i])
            );
        end else begin : g_absent
            assign pend_q[i] = 1'b0;
            assign pend_d[i] = 1'b0;
        end
    end

    irqc_irq_out u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_nxt (pend_d),
        .irq_o    (irq_o)
    );

    assign rd_data = pend_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter logic [7:0] VALID = 8'h3F
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] evt_i,
    input logic [7:0] en_q,
    input logic [7:0] rd_data,
    input logic       irq_o
);
    logic [7:0] hit;
    logic [7:0] keep;
    always_comb begin
        keep = wr_en ? wr_data : 8'hFF;
        hit  = evt_i & en_q & keep;
    end

    // R2: an event on an enabled source that is not disabled shows up next cycle
    a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rd_data & $past(hit)) == $past(hit)));

    // R5 / R7: a written zero clears the pending bit
    a_r5_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_data & ~$past(wr_data)) == 8'h00));

    // R8: bits outside the valid mask never read as pending
    a_r8_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~VALID) == 8'h00);

    // R9: interrupt level tracks the pending vector
    a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (rd_data != 8'h00));

    // R4: without write or event nothing moves
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && evt_i == 8'h00) |=> $stable(rd_data));
endmodule

bind evt_irq_ctl irqc_checker #(.VALID(VALID_MASK)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .evt_i   (evt_i),
    .en_q    (en_q),
    .rd_data (rd_data),
    .irq_o   (irq_o)
);

// File: tb/evt_irq_ctl_test.sv
module evt_irq_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] VALID = 8'h3F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] evt_i = 8'h00;
    logic [7:0] rd_data;
    logic       irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] exp_rd_q[$];
    logic       exp_irq_q[$];
    string      tag_q[$];

    logic [7:0] m_en = 8'h00;
    logic [7:0] m_st = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_ctl #(.VALID_MASK(VALID)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .evt_i(evt_i), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic compare(input logic [7:0] er, input logic ei, input string tag);
        n_cmp++;
        if (rd_data !== er || irq_o !== ei) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                     tag, rd_data, irq_o, er, ei);
        end
    endtask

    // driver: apply one cycle of stimulus, advance the model, push expectation
    task automatic step(input logic w, input logic [7:0] wd, input logic [7:0] ev,
                        input string tag);
        logic [7:0] nen;
        @(negedge clk);
        wr_en = w; wr_data = wd; evt_i = ev;
        nen  = w ? (wd & VALID) : m_en;
        m_st = (m_st | (ev & m_en & VALID)) & nen;
        m_en = nen;
        @(posedge clk);
        #1;
        exp_rd_q.push_back(m_st);
        exp_irq_q.push_back(|m_st);
        tag_q.push_back(tag);
    endtask

    // monitor: compare as results are produced
    initial begin
        forever begin
            wait (exp_rd_q.size() > 0);
            compare(exp_rd_q.pop_front(), exp_irq_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        evt_i = 8'hFF; wr_en = 1'b1; wr_data = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(8'h00, 1'b0, "R1 in reset");
        wr_en = 1'b0; evt_i = 8'h00;
        rst_n = 1'b1;
        step(1'b0, 8'h00, 8'h3F, "R1 events after reset discarded");
        step(1'b1, 8'h3F, 8'h00, "R2 write mask");
        step(1'b0, 8'h00, 8'h01, "R2 event src0");
        step(1'b0, 8'h00, 8'h05, "R4 sticky plus src2");
        step(1'b0, 8'h00, 8'hC0, "R8 invalid events");
        step(1'b1, 8'h3E, 8'h00, "R5 ack src0");
        step(1'b1, 8'h3F, 8'h00, "R5 re-enable does not restore");
        step(1'b0, 8'h00, 8'h01, "R6 new event after re-enable");
        step(1'b1, 8'h3F, 8'h01, "R4 write keeping enable");
        step(1'b1, 8'h3B, 8'h00, "R5 ack src2");
        step(1'b1, 8'hFF, 8'hC4, "R10 enable and event same cycle");
        step(1'b0, 8'h00, 8'h04, "R10 enable effective next cycle");
        step(1'b1, 8'h3A, 8'h01, "R7 disable beats event");
        step(1'b1, 8'h00, 8'h00, "R5 write zero clears all");
        step(1'b0, 8'h00, 8'hFF, "R3 disabled sources discard");
        step(1'b1, 8'h3F, 8'h00, "R3 discarded events stay gone");
        step(1'b0, 8'h00, 8'h20, "R9 irq from top valid source");
        lfsr = 8'hA5;
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[0] & lfsr[3], {lfsr[2:0], lfsr[7:3]}, lfsr, "R2 mixed traffic");
        end
        step(1'b0, 8'h00, 8'h00, "R9 idle");
        wait (exp_rd_q.size() == 0);
        #1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule